// File: doc/BRIEF.md
# Duplicated-Unit Compare and Retry Recovery Controller

This block checks a processor core whose fetch/decode stage and execute stage are each built twice. Every cycle it compares the two decode results and the two execute results, including their valid strobes. The comparison runs in a separate recovery unit, off the critical datapath. The recovery unit also holds a checkpoint register file that records only results both copies agree on. Because the level-1 cache writes through, the checkpoint never has to capture dirty cache lines.

When the copies disagree, the checkpoint is not written. For one cycle the block asks the pipelines to restore from the checkpoint, and then it waits for the instruction to be executed again. A clean re-execution commits, clears the error flag and adds one to a saturating count of successful retries. A second disagreement stops the processor. The block then streams the checkpoint out, one word per handshake, so that the recovery unit of a spare processor can continue from the saved state. A done pulse marks the end of the stream.

Top module: `lockstep_rcu`

## Requirements
- R1: After reset, commit_en, retry_req, err_flag, stop, xfer_valid and xfer_done are 0, retry_cnt is 0, and every checkpoint register holds 0.
- R2: In normal or retry operation, commit_en is high in the same cycle that both execute valids are high, both execute copies carry equal destination and result, and the decode pair agrees. At the next edge, checkpoint register exe_a_dst takes exe_a_res.
- R3: A mismatch is one of the following, in either pair: the valid strobes differ, or both valids are high and the payloads differ. A mismatch holds commit_en low in that cycle, and err_flag is set from the next cycle.
- R4: After a mismatch in normal operation, retry_req is high for exactly one cycle, the cycle after the mismatch.
- R5: After that restore cycle, the first agreeing execute result commits, clears err_flag and increments retry_cnt at the next edge.
- R6: A mismatch while waiting for the retry sets stop from the next cycle, and no commit happens. stop then stays high until reset.
- R7: One cycle after stop rises, xfer_valid goes high. Word k of the stream is checkpoint register k, k rising from 0. A word advances only on a cycle with xfer_valid and xfer_ready both high, and xfer_data holds steady while xfer_ready is low.
- R8: In the cycle after the last word is accepted, xfer_done is high for one cycle and xfer_valid falls. After that no further stream starts, and commit_en stays low for as long as stop is high.
- R9: retry_cnt saturates at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_a_vld | input | 1 | Decode copy A valid |
| dec_a_bus | input | DW | Decode copy A result |
| dec_b_vld | input | 1 | Decode copy B valid |
| dec_b_bus | input | DW | Decode copy B result |
| exe_a_vld | input | 1 | Execute copy A valid |
| exe_a_dst | input | AW | Execute copy A destination register |
| exe_a_res | input | DW | Execute copy A result |
| exe_b_vld | input | 1 | Execute copy B valid |
| exe_b_dst | input | AW | Execute copy B destination register |
| exe_b_res | input | DW | Execute copy B result |
| commit_en | output | 1 | Checkpoint write in this cycle |
| retry_req | output | 1 | Restore from checkpoint and re-execute |
| err_flag | output | 1 | Unresolved mismatch pending |
| stop | output | 1 | Processor stopped |
| retry_cnt | output | CNT_W | Successful retries, saturating |
| xfer_valid | output | 1 | Checkpoint word offered to the spare |
| xfer_ready | input | 1 | Spare accepts the word |
| xfer_data | output | DW | Checkpoint word |
| xfer_done | output | 1 | One-cycle pulse after the last word |

## Verification
The bench builds the block with NREGS=4, CNT_W=2 and DW=32. Four checkpoint registers keep the whole stream to the spare short enough to check word by word, including a stalled word. A two-bit counter reaches saturation after three successful retries, so the bench retries a fourth time and confirms that the count stays at 3. Each kind of mismatch is exercised on its own: a decode payload mismatch, an execute valid mismatch and an execute data mismatch.

// File: rtl/lockstep_rcu.sv
module lockstep_rcu #(
  parameter int DW = 32,
  parameter int NREGS = 8,
  parameter int CNT_W = 8,
  localparam int AW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_a_vld,
  input  logic [DW-1:0]    dec_a_bus,
  input  logic             dec_b_vld,
  input  logic [DW-1:0]    dec_b_bus,
  input  logic             exe_a_vld,
  input  logic [AW-1:0]    exe_a_dst,
  input  logic [DW-1:0]    exe_a_res,
  input  logic             exe_b_vld,
  input  logic [AW-1:0]    exe_b_dst,
  input  logic [DW-1:0]    exe_b_res,
  output logic             commit_en,
  output logic             retry_req,
  output logic             err_flag,
  output logic             stop,
  output logic [CNT_W-1:0] retry_cnt,
  output logic             xfer_valid,
  input  logic             xfer_ready,
  output logic [DW-1:0]    xfer_data,
  output logic             xfer_done
);
  typedef enum logic [2:0] {S_NORM, S_REST, S_RETRY, S_STOP, S_XFER} st_t;

  st_t           st;
  logic [DW-1:0] ckpt [NREGS];
  logic [AW-1:0] xidx;
  logic          sent, done_r;

  wire dec_bad = (dec_a_vld != dec_b_vld) ||
                 (dec_a_vld && dec_b_vld && dec_a_bus != dec_b_bus);
  wire exe_bad = (exe_a_vld != exe_b_vld) ||
                 (exe_a_vld && exe_b_vld &&
                  (exe_a_res != exe_b_res || exe_a_dst != exe_b_dst));
  wire mis  = dec_bad || exe_bad;
  wire live = (st == S_NORM) || (st == S_RETRY);
  wire last = (xidx == AW'(NREGS - 1));

  assign commit_en  = live && !mis && exe_a_vld && exe_b_vld;
  assign retry_req  = (st == S_REST);
  assign stop       = (st == S_STOP) || (st == S_XFER);
  assign xfer_valid = (st == S_XFER);
  assign xfer_data  = ckpt[xidx];
  assign xfer_done  = done_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) ckpt[i] <= '0;
    end else if (commit_en) begin
      ckpt[exe_a_dst] <= exe_a_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_NORM;
      err_flag  <= 1'b0;
      retry_cnt <= '0;
      xidx      <= '0;
      sent      <= 1'b0;
      done_r    <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_NORM:
          if (mis) begin
            st       <= S_REST;
            err_flag <= 1'b1;
          end
        S_REST:
          st <= S_RETRY;
        S_RETRY:
          if (mis) begin
            st <= S_STOP;
          end else if (commit_en) begin
            st       <= S_NORM;
            err_flag <= 1'b0;
            if (retry_cnt != '1) retry_cnt <= retry_cnt + CNT_W'(1);
          end
        S_STOP:
          if (!sent) begin
            st   <= S_XFER;
            xidx <= '0;
          end
        S_XFER:
          if (xfer_ready) begin
            if (last) begin
              st     <= S_STOP;
              sent   <= 1'b1;
              done_r <= 1'b1;
            end else begin
              xidx <= xidx + AW'(1);
            end
          end
        default:
          st <= S_STOP;
      endcase
    end
  end
endmodule

// File: rtl/lockstep_rcu_chk.sv
module lockstep_rcu_chk #(
  parameter int DW = 32,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exe_a_vld,
  input logic             exe_b_vld,
  input logic             commit_en,
  input logic             retry_req,
  input logic             stop,
  input logic [CNT_W-1:0] retry_cnt,
  input logic             xfer_valid,
  input logic             xfer_ready,
  input logic [DW-1:0]    xfer_data,
  input logic             xfer_done
);
  assert_commit_needs_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> (exe_a_vld && exe_b_vld));

  assert_valid_split_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_a_vld != exe_b_vld) |-> !commit_en);

  assert_retry_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |=> !retry_req);

  assert_stop_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> stop);

  assert_stream_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_data)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  assert_no_commit_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !commit_en);

  assert_cnt_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (retry_cnt >= $past(retry_cnt)));
endmodule

bind lockstep_rcu lockstep_rcu_chk #(.DW(DW), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/lockstep_rcu_tb_top.sv
module lockstep_rcu_tb_top;
  localparam int DW = 32, NREGS = 4, CNT_W = 2, AW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dec_a_vld, dec_b_vld, exe_a_vld, exe_b_vld, xfer_ready;
  logic [DW-1:0] dec_a_bus, dec_b_bus, exe_a_res, exe_b_res;
  logic [AW-1:0] exe_a_dst, exe_b_dst;
  logic commit_en, retry_req, err_flag, stop, xfer_valid, xfer_done;
  logic [CNT_W-1:0] retry_cnt;
  logic [DW-1:0] xfer_data;

  int checks = 0, fails = 0;
  bit over = 0;
  logic [DW-1:0] exp_reg [NREGS];

  always #5 clk = ~clk;

  lockstep_rcu #(.DW(DW), .NREGS(NREGS), .CNT_W(CNT_W)) dut_i (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    dec_a_vld = 0; dec_b_vld = 0; exe_a_vld = 0; exe_b_vld = 0;
    dec_a_bus = '0; dec_b_bus = '0; exe_a_res = '0; exe_b_res = '0;
    exe_a_dst = '0; exe_b_dst = '0;
  endtask

  // kind: 0 agree, 1 decode payload split, 2 execute valid split, 3 execute data split
  task automatic put(int dst, logic [DW-1:0] val, int kind);
    dec_a_vld = 1; dec_b_vld = 1;
    dec_a_bus = val ^ 32'h5A5A; dec_b_bus = (kind == 1) ? ~dec_a_bus : dec_a_bus;
    exe_a_vld = 1; exe_b_vld = (kind != 2);
    exe_a_dst = AW'(dst); exe_b_dst = AW'(dst);
    exe_a_res = val; exe_b_res = (kind == 3) ? val ^ 32'h1 : val;
  endtask

  task automatic t_reset();
    chk("R1 commit_en", commit_en, 0);
    chk("R1 retry_req", retry_req, 0);
    chk("R1 err_flag", err_flag, 0);
    chk("R1 stop", stop, 0);
    chk("R1 retry_cnt", retry_cnt, 0);
    chk("R1 xfer_valid", xfer_valid, 0);
    chk("R1 xfer_done", xfer_done, 0);
  endtask

  task automatic t_commit(int dst, logic [DW-1:0] val);
    put(dst, val, 0); #1;
    chk("R2 commit", commit_en, 1);
    tick(); exp_reg[dst] = val; idle(); #1;
    chk("R2 idle no commit", commit_en, 0);
  endtask

  task automatic t_retry(int kind, int dst, logic [DW-1:0] bad, logic [DW-1:0] good, int exp_cnt);
    put(dst, bad, kind); #1;
    chk("R3 mismatch blocks commit", commit_en, 0);
    tick(); idle();
    chk("R3 err_flag set", err_flag, 1);
    chk("R4 retry_req high", retry_req, 1);
    tick();
    chk("R4 retry_req one cycle", retry_req, 0);
    put(dst, good, 0); #1;
    chk("R5 retry commit", commit_en, 1);
    tick(); exp_reg[dst] = good; idle();
    chk("R5 err_flag cleared", err_flag, 0);
    chk("R5 R9 retry_cnt", retry_cnt, exp_cnt);
  endtask

  task automatic t_stop_and_stream();
    put(2, 32'hDEAD_0002, 3); #1;
    tick(); idle();
    chk("R4 retry_req", retry_req, 1);
    tick();
    put(2, 32'hBAD0_0002, 3); #1;
    chk("R6 no commit on second mismatch", commit_en, 0);
    tick(); idle();
    chk("R6 stop", stop, 1);
    chk("R7 no stream yet", xfer_valid, 0);
    put(1, 32'hFFFF_0001, 0); #1;
    chk("R8 commit blocked while stopped", commit_en, 0);
    tick(); idle();
    for (int i = 0; i < NREGS; i++) begin
      if (i == 1) begin
        xfer_ready = 0; #1;
        chk("R7 valid", xfer_valid, 1);
        chk("R7 word", xfer_data, exp_reg[i]);
        tick();
        chk("R7 held word", xfer_data, exp_reg[i]);
      end
      xfer_ready = 1; #1;
      chk("R7 valid", xfer_valid, 1);
      chk("R7 word", xfer_data, exp_reg[i]);
      tick();
    end
    xfer_ready = 0;
    chk("R8 done", xfer_done, 1);
    chk("R8 valid falls", xfer_valid, 0);
    tick();
    chk("R8 done pulse", xfer_done, 0);
    chk("R8 no restart", xfer_valid, 0);
    chk("R6 stop sticky", stop, 1);
    tick();
    chk("R8 no restart later", xfer_valid, 0);
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    idle(); xfer_ready = 0;
    for (int i = 0; i < NREGS; i++) exp_reg[i] = '0;
    repeat (3) @(posedge clk);
    #1; t_reset();
    rst_n = 1;
    tick(); t_reset();
    dec_a_vld = 1; dec_b_vld = 1; dec_a_bus = 32'h7; dec_b_bus = 32'h7; #1;
    chk("R2 decode only no commit", commit_en, 0);
    tick(); idle();
    t_commit(0, 32'h1111_0000);
    t_commit(1, 32'h2222_0001);
    t_commit(2, 32'h3333_0002);
    t_commit(3, 32'h4444_0003);
    t_retry(1, 3, 32'hAAAA_0003, 32'h5555_0003, 1);
    t_retry(2, 0, 32'hBBBB_0000, 32'h6666_0000, 2);
    t_retry(3, 1, 32'hCCCC_0001, 32'h7777_0001, 3);
    t_retry(3, 2, 32'hEEEE_0002, 32'h8888_0002, 3);
    t_commit(1, 32'h9999_0001);
    t_stop_and_stream();
    finish_run();
  end
endmodule